// File: doc/BRIEF.md
# Sparse Timestamped Pixel Readout

This block holds the digital side of a hit-detecting pixel matrix. During an acquisition window every pixel watches its own discriminated hit line. The first hit a pixel sees in a bunch train sets its hit flag and freezes the current time-slice number. Time slices are counted by a small counter that steps once per slice strobe and stops at its top value.

Nothing leaves the block while it is acquiring. A readout command starts a separate phase in which a sequencer walks the matrix row by row. Within a row a look-ahead encoder jumps straight to the next flagged pixel, so each flagged pixel costs one cycle and an empty row costs one cycle. The row and column numbers of each emitted word come from the sequencer's own pointers. A test control makes the sequencer emit every pixel regardless of its flag. Words leave on a valid/ready stream, and a one-cycle done pulse marks the end of the pass.

Top module: `pix_sparse_readout`

## Requirements
- R1: A `trainStart` pulse, accepted while idle or acquiring, clears every hit flag and stored stamp, sets the slice counter to 0 and enters acquisition. A later readout shows none of the hits recorded before it.
- R2: While acquiring, the first hit on a pixel sets its flag and stores the current slice value (0 to 31). Further hits on that pixel in the same train leave the stored value unchanged.
- R3: Each `sliceTick` in acquisition advances the counter by one. A hit in the same cycle as a tick gets the value before the tick. A tick while the counter is 31 holds it at 31 and closes the capture window, so every later hit in that train is ignored.
- R4: No word is valid during acquisition. `readStart`, accepted while idle or acquiring, begins readout, and hits and `trainStart` that arrive during readout have no effect.
- R5: In sparse mode only flagged pixels are emitted, rows in ascending order and columns in ascending order within a row. The word is {row, col, stamp}, with the row in bits [16:11], the column in [10:5] and the stamp in [4:0] for the default 64 x 64 matrix.
- R6: With `outReady` high, flagged pixels in one row come out on consecutive cycles. A row with no remaining candidate uses exactly one cycle with `outValid` low.
- R7: While `outValid` is high and `outReady` is low, `outData` and `outValid` hold. The sequencer advances only on a cycle where both are high.
- R8: Emitting a pixel clears its flag, so a second sparse readout with no new train emits nothing.
- R9: With `readAll` high at `readStart`, every pixel is emitted in row-major order with its stored stamp, and pixels that were not hit show stamp 0.
- R10: After the last row, `readDone` is high for exactly one cycle and the block returns to idle. After reset the block is idle with `outValid` and `readDone` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trainStart | input | 1 | Start of bunch train: clear and begin acquisition |
| sliceTick | input | 1 | Time-slice strobe |
| hitIn | input | ROWS*COLS | Discriminated hits, pixel (r,c) at bit r*COLS+c |
| readStart | input | 1 | Begin a readout pass |
| readAll | input | 1 | Test control: emit every pixel (sampled at readStart) |
| outReady | input | 1 | Downstream ready |
| outValid | output | 1 | Output word valid |
| outData | output | ROW_W+COL_W+TS_W | {row, col, stamp} |
| readDone | output | 1 | One-cycle end-of-pass pulse |

## Verification
The coincidences that matter most are a hit landing in the same cycle as a slice tick, and a hit landing in the same cycle as the tick that saturates the counter. The bench drives those pulses together on one negative edge. A behavioural model stamps the pixel with the pre-tick value and closes the window after the saturating tick. A second coincidence is a `trainStart` or a hit arriving while readout is stalled by a low `outReady`. The model ignores both, and the stream is compared on every cycle against the model's expected valid, word and done values.

// File: rtl/pix_pkg.sv
package pix_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_READ = 2'd2,
    ST_DONE = 2'd3
  } rdState_t;

  // strobes from the sequencer to the pixel datapath
  typedef struct packed {
    logic clearAll;
    logic captureEn;
    logic startRead;
    logic skipRow;
    logic popWord;
    logic readAllMode;
  } dpStrobe_t;

endpackage

// File: rtl/pix_datapath.sv
module pix_datapath
  import pix_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int TS_W = 5,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int NPIX  = ROWS * COLS,
  localparam int WORD_W = ROW_W + COL_W + TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strb,
  input  logic [TS_W-1:0]   timeVal,
  input  logic [NPIX-1:0]   hitIn,
  output logic              candAny,
  output logic              atLastRow,
  output logic              hitAtLastCol,
  output logic [WORD_W-1:0] wordOut
);

  logic [ROWS-1:0][COLS-1:0]            hitLatch;
  logic [ROWS-1:0][COLS-1:0][TS_W-1:0]  tsStore;
  logic [ROW_W-1:0] rowPtr;
  logic [COL_W-1:0] colPtr;

  logic [COLS-1:0]  rowBits;
  logic [COLS-1:0]  geMask;
  logic [COLS-1:0]  cand;
  logic [COL_W-1:0] hitCol;

  assign rowBits = hitLatch[rowPtr];

  // columns at or right of the pointer
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      geMask[c] = (COL_W'(c) >= colPtr);
    end
  end

  assign cand = (strb.readAllMode ? {COLS{1'b1}} : rowBits) & geMask;

  // look-ahead: lowest remaining candidate column
  always_comb begin
    hitCol = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (cand[c]) hitCol = COL_W'(c);
    end
  end

  assign candAny      = |cand;
  assign atLastRow    = (rowPtr == ROW_W'(ROWS - 1));
  assign hitAtLastCol = (hitCol == COL_W'(COLS - 1));
  assign wordOut      = {rowPtr, hitCol, tsStore[rowPtr][hitCol]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitLatch <= '0;
      tsStore  <= '0;
      rowPtr   <= '0;
      colPtr   <= '0;
    end else begin
      if (strb.clearAll) begin
        hitLatch <= '0;
        tsStore  <= '0;
      end else if (strb.captureEn) begin
        for (int r = 0; r < ROWS; r++) begin
          for (int c = 0; c < COLS; c++) begin
            if (hitIn[r*COLS + c] && !hitLatch[r][c]) begin
              hitLatch[r][c] <= 1'b1;
              tsStore[r][c]  <= timeVal;
            end
          end
        end
      end
      if (strb.popWord) begin
        hitLatch[rowPtr][hitCol] <= 1'b0;
      end
      if (strb.startRead) begin
        rowPtr <= '0;
        colPtr <= '0;
      end else if (strb.skipRow) begin
        rowPtr <= rowPtr + 1'b1;
        colPtr <= '0;
      end else if (strb.popWord) begin
        if (hitAtLastCol) begin
          rowPtr <= rowPtr + 1'b1;
          colPtr <= '0;
        end else begin
          colPtr <= hitCol + 1'b1;
        end
      end
    end
  end

  // R8
  pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.popWord |=> !hitLatch[$past(rowPtr)][$past(hitCol)]);

  // R2
  stamp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hitLatch[0][0] && !strb.clearAll) |=> $stable(tsStore[0][0]));

  // R4
  no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.clearAll && !strb.captureEn) |=> $stable(tsStore));

endmodule

// File: rtl/pix_readout_ctrl.sv
module pix_readout_ctrl
  import pix_pkg::*;
#(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trainStart,
  input  logic            sliceTick,
  input  logic            readStart,
  input  logic            readAll,
  input  logic            outReady,
  input  logic            candAny,
  input  logic            atLastRow,
  input  logic            hitAtLastCol,
  output dpStrobe_t       strb,
  output logic [TS_W-1:0] timeVal,
  output logic            outValid,
  output logic            readDone
);

  localparam logic [TS_W-1:0] TS_MAX = '1;

  rdState_t state, stateNxt;
  logic [TS_W-1:0] timeCnt;
  logic expired;
  logic allMode;

  always_comb begin
    stateNxt = state;
    strb = '0;
    strb.readAllMode = allMode;
    case (state)
      ST_IDLE: begin
        if (trainStart) begin
          strb.clearAll = 1'b1;
          stateNxt = ST_ACQ;
        end else if (readStart) begin
          strb.startRead = 1'b1;
          stateNxt = ST_READ;
        end
      end
      ST_ACQ: begin
        if (trainStart) begin
          strb.clearAll = 1'b1;
        end else begin
          strb.captureEn = !expired;
          if (readStart) begin
            strb.startRead = 1'b1;
            stateNxt = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (!candAny) begin
          if (atLastRow) stateNxt = ST_DONE;
          else strb.skipRow = 1'b1;
        end else if (outReady) begin
          strb.popWord = 1'b1;
          if (atLastRow && hitAtLastCol) stateNxt = ST_DONE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      timeCnt <= '0;
      expired <= 1'b0;
      allMode <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strb.startRead) allMode <= readAll;
      if (strb.clearAll) begin
        timeCnt <= '0;
        expired <= 1'b0;
      end else if (state == ST_ACQ && sliceTick) begin
        if (timeCnt == TS_MAX) expired <= 1'b1;
        else timeCnt <= timeCnt + 1'b1;
      end
    end
  end

  assign timeVal  = timeCnt;
  assign outValid = (state == ST_READ) && candAny;
  assign readDone = (state == ST_DONE);

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACQ && timeCnt == TS_MAX && sliceTick && !trainStart)
      |=> (timeCnt == TS_MAX && expired));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readDone |=> (!readDone && state == ST_IDLE));

  // R4
  read_ignores_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && trainStart) |-> !strb.clearAll);

endmodule

// File: rtl/pix_sparse_readout.sv
module pix_sparse_readout
  import pix_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int TS_W = 5,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int NPIX  = ROWS * COLS,
  localparam int WORD_W = ROW_W + COL_W + TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trainStart,
  input  logic              sliceTick,
  input  logic [NPIX-1:0]   hitIn,
  input  logic              readStart,
  input  logic              readAll,
  input  logic              outReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic              readDone
);

  dpStrobe_t       strb;
  logic [TS_W-1:0] timeVal;
  logic            candAny;
  logic            atLastRow;
  logic            hitAtLastCol;

  pix_readout_ctrl #(.TS_W(TS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trainStart(trainStart), .sliceTick(sliceTick),
    .readStart(readStart), .readAll(readAll), .outReady(outReady),
    .candAny(candAny), .atLastRow(atLastRow), .hitAtLastCol(hitAtLastCol),
    .strb(strb), .timeVal(timeVal), .outValid(outValid), .readDone(readDone)
  );

  pix_datapath #(.ROWS(ROWS), .COLS(COLS), .TS_W(TS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .timeVal(timeVal), .hitIn(hitIn),
    .candAny(candAny), .atLastRow(atLastRow), .hitAtLastCol(hitAtLastCol),
    .wordOut(outData)
  );

  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readDone |-> !outValid);

endmodule

// File: tb/pix_sparse_readout_bench.sv
module pix_sparse_readout_bench;

  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int NPIX = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trainStart = 1'b0, sliceTick = 1'b0, readStart = 1'b0, readAll = 1'b0;
  logic outReady = 1'b1;
  logic [NPIX-1:0] hitIn = '0;
  logic outValid, readDone;
  logic [16:0] outData;

  always #5 clk = ~clk;

  pix_sparse_readout u_pix_sparse_readout (
    .clk(clk), .rst_n(rst_n), .trainStart(trainStart), .sliceTick(sliceTick),
    .hitIn(hitIn), .readStart(readStart), .readAll(readAll), .outReady(outReady),
    .outValid(outValid), .outData(outData), .readDone(readDone)
  );

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;
  bit readyMode = 1;
  string tag = "R10";

  // behavioural reference
  bit mLatch[ROWS][COLS];
  int mTs[ROWS][COLS];
  int mState = 0, mT = 0, mRow = 0, mCol = 0;
  bit mExp = 0, mAll = 0;

  function automatic int findCand();
    for (int c = mCol; c < COLS; c++) if (mAll || mLatch[mRow][c]) return c;
    return -1;
  endfunction

  task automatic mClear();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin mLatch[r][c] = 0; mTs[r][c] = 0; end
    mT = 0; mExp = 0;
  endtask

  task automatic mBeginRead();
    mState = 2; mRow = 0; mCol = 0; mAll = readAll;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mClear(); mState = 0; mRow = 0; mCol = 0; mAll = 0;
    end else begin
      case (mState)
        0: if (trainStart) begin mClear(); mState = 1; end
           else if (readStart) mBeginRead();
        1: if (trainStart) mClear();
           else begin
             if (!mExp)
               for (int r = 0; r < ROWS; r++)
                 for (int c = 0; c < COLS; c++)
                   if (hitIn[r*COLS+c] && !mLatch[r][c]) begin mLatch[r][c] = 1; mTs[r][c] = mT; end
             if (sliceTick) begin if (mT == 31) mExp = 1; else mT++; end
             if (readStart) mBeginRead();
           end
        2: begin
             int c;
             c = findCand();
             if (c < 0) begin
               if (mRow == ROWS-1) mState = 3; else begin mRow++; mCol = 0; end
             end else if (outReady) begin
               mLatch[mRow][c] = 0;
               if (c == COLS-1) begin
                 if (mRow == ROWS-1) mState = 3; else begin mRow++; mCol = 0; end
               end else mCol = c + 1;
             end
           end
        default: mState = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      int c;
      bit expV;
      logic [16:0] expD;
      c = (mState == 2) ? findCand() : -1;
      expV = (c >= 0);
      expD = (c >= 0) ? {mRow[5:0], c[5:0], mTs[mRow][c][4:0]} : '0;
      total++;
      if (outValid !== expV) begin
        bad++; $display("FAIL %s valid: got %0b exp %0b (cycle %0d)", tag, outValid, expV, cycles);
      end
      if (expV) begin
        total++;
        if (outData !== expD) begin
          bad++; $display("FAIL %s data: got %h exp %h (cycle %0d)", tag, outData, expD, cycles);
        end
      end
      total++;
      if (readDone !== (mState == 3)) begin
        bad++; $display("FAIL %s done: got %0b exp %0b", tag, readDone, (mState == 3));
      end
      outReady <= readyMode ? 1'b1 : ((cycles % 3) != 0);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTrain();
    trainStart = 1; step(); trainStart = 0;
  endtask

  task automatic hit(int r, int c);
    hitIn[r*COLS+c] = 1'b1;
  endtask

  task automatic waitDone();
    int n = 0;
    while (readDone !== 1'b1 && n < 6000) begin step(); n++; end
    step();
  endtask

  task automatic doRead(bit all);
    readAll = all; readStart = 1; step(); readStart = 0; readAll = 0;
    waitDone();
  endtask

  initial begin
    step(3);
    // R10: reset state
    total++;
    if (outValid !== 1'b0 || readDone !== 1'b0) begin
      bad++; $display("FAIL R10 reset: got v=%0b d=%0b exp 0 0", outValid, readDone);
    end
    rst_n = 1; step();

    // R2 R3: first-hit stamping, tick coincidence, saturation
    tag = "R2,R3";
    pulseTrain();
    hit(0, 5); hit(2, 10); step(); hitIn = '0;
    sliceTick = 1; step(); sliceTick = 0;
    hit(0, 5); hit(0, 6); step(); hitIn = '0;
    hit(3, 3); sliceTick = 1; step(); sliceTick = 0; hitIn = '0;
    repeat (29) begin sliceTick = 1; step(); end
    sliceTick = 0;
    hit(5, 7); step(); hitIn = '0;
    hit(5, 8); sliceTick = 1; step(); sliceTick = 0; hitIn = '0;
    hit(6, 8); step(); hitIn = '0;
    repeat (5) begin sliceTick = 1; step(); end
    sliceTick = 0;
    hit(7, 9); step(); hitIn = '0;
    // R7: stalled stream, with R4 disturbances during readout
    tag = "R7";
    readyMode = 0;
    readStart = 1; step(); readStart = 0;
    step(2);
    hit(9, 9); trainStart = 1; step(); hitIn = '0; trainStart = 0;
    waitDone();
    readyMode = 1;

    // R8: second pass without new train is empty
    tag = "R8";
    doRead(0);

    // R5 R6 R4 R10: ordering, look-ahead, row ends, ignored disturbances
    tag = "R5,R6";
    pulseTrain();
    for (int c = 0; c < 4; c++) hit(1, c);
    hit(63, 63); hit(0, 0); hit(10, 62); hit(10, 63); hit(11, 0); hit(0, 63);
    step(); hitIn = '0;
    sliceTick = 1; step(); sliceTick = 0;
    hit(40, 17); step(); hitIn = '0;
    tag = "R4,R10";
    readStart = 1; step(); readStart = 0;
    step(2);
    hit(20, 20); trainStart = 1; step(); hitIn = '0; trainStart = 0;
    waitDone();

    // R1: train start discards previous hits
    tag = "R1";
    pulseTrain();
    hit(4, 4); hit(30, 31); step(); hitIn = '0;
    pulseTrain();
    step();
    doRead(0);

    // R9: read-all pass
    tag = "R9";
    pulseTrain();
    sliceTick = 1; step(); sliceTick = 0;
    hit(0, 1); hit(63, 0); step(); hitIn = '0;
    doRead(1);

    step(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule